// File: doc/BRIEF.md
# Clock-Referenced Pulse Position Monitor

This block builds a picture of where a periodic alignment pulse lands within the reference-clock period. An external delay line offers 24 candidate sampling instants, each a delayed copy of the reference-clock edge. For each instant an external sampler reports, at every pulse, whether the pulse transition came too close to that instant to be captured safely. The block turns those per-pulse reports into one 24-bit status vector. A bit set to 1 marks a risky position, and a bit at 0 marks a usable one. System software reads the vector and then picks a sampling instant near the middle of a run of zeros.

Reports are merged with a logical OR over every pulse rising edge seen since the last restart. A valid flag rises only after three edges have been merged. The two outermost positions are always reported as risky, because nothing beyond them shows how much margin they have. The block also holds a zoom setting that it passes to the delay line: 0 selects coarse tap spacing and 1 selects fine tap spacing. A change of zoom makes the earlier observations meaningless, so it starts a new accumulation.

Top module: `pulse_window_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, `status_out` equals 0x800001 (bit 0 and bit 23 set, all others clear), `valid_out` is 0 and `zoom_out` is 0.
- R2: Bit i of `status_out` (bit 0 = smallest delay, bit 23 = largest) is 1 exactly when at least one accumulated pulse edge since the last restart had bit i of `marginal_in` set. The vector never loses a 1 except on a restart.
- R3: Bits 0 and 23 of `status_out` always read 1, whatever `marginal_in` carries.
- R4: `valid_out` is 0 until three pulse rising edges have been accumulated since the last restart. It is 1 from the third edge on and stays 1 through any further edges until a restart.
- R5: Only a 0-to-1 transition of `pulse_in` counts as an edge. A pulse held high for many cycles counts once. `marginal_in` has no effect in any cycle other than the one in which the rising pulse is captured.
- R6: A cycle with `restart` high returns `status_out` to 0x800001 and `valid_out` to 0 on the following clock edge, and it restarts the edge count from zero.
- R7: `zoom_out` takes the value of `zoom_in` one clock edge later. 0 means coarse and 1 means fine. Any cycle in which `zoom_in` differs from `zoom_out` clears the vector, the count and the valid flag as `restart` does. Holding `zoom_in` steady clears nothing.
- R8: Take a rising `pulse_in` together with `marginal_in` sampled on clock edge k. That edge's contribution appears on `status_out` and `valid_out` after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Synchronous restart of the accumulation |
| zoom_in | input | 1 | Requested tap spacing, 0 coarse, 1 fine |
| pulse_in | input | 1 | Alignment pulse, already in the clock domain |
| marginal_in | input | 24 | Per-position marginal report from the sampler |
| zoom_out | output | 1 | Registered tap spacing sent to the delay line |
| status_out | output | 24 | Accumulated per-position violation vector |
| valid_out | output | 1 | Vector reflects at least three pulse edges |

## Verification
The assertions assume three things about the inputs. `pulse_in` is already synchronous to `clk`. `marginal_in` is stable on the edge that captures a rising pulse. `zoom_in` changes only when software means to start a new measurement. The bench drives every input on the falling clock edge, so each value is steady across the capturing rising edge. Between pulses it deliberately drives unrelated values on `marginal_in`, which checks that only the captured sample is used. Each pulse is low for at least one cycle before it rises again, so every intended edge shows up as a real 0-to-1 transition.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  function automatic int count_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/pwm_edge_detect.sv
module pwm_edge_detect #(
  parameter int NUM_POS = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pulse_in,
  input  logic [NUM_POS-1:0] marginal_in,
  output logic               rise,
  output logic [NUM_POS-1:0] marginal_q
);
  logic pulse_q;
  logic pulse_qq;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q    <= 1'b0;
      pulse_qq   <= 1'b0;
      marginal_q <= '0;
    end else begin
      pulse_q    <= pulse_in;
      pulse_qq   <= pulse_q;
      marginal_q <= marginal_in;
    end
  end

  assign rise = pulse_q & ~pulse_qq;

  // R5: a detected edge can never repeat on the very next cycle
  assert_single_rise_R5: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/pwm_edge_counter.sv
module pwm_edge_counter
  import pwm_pkg::*;
#(
  parameter int EDGES_NEEDED = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic valid
);
  localparam int CW = count_width(EDGES_NEEDED);
  localparam logic [CW-1:0] LAST = CW'(EDGES_NEEDED - 1);
  localparam logic [CW-1:0] FULL = CW'(EDGES_NEEDED);

  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
      valid <= 1'b0;
    end else if (step && count != FULL) begin
      count <= count + 1'b1;
      if (count == LAST) valid <= 1'b1;
    end
  end

  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    count <= FULL);

  assert_valid_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && !clear) |=> valid);

  assert_valid_matches_count_R4: assert property (@(posedge clk) disable iff (rst)
    valid == (count == FULL));

  assert_clear_drops_valid_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> !valid);
endmodule

// File: rtl/pwm_accum.sv
module pwm_accum #(
  parameter int NUM_POS = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               step,
  input  logic [NUM_POS-1:0] sample,
  output logic [NUM_POS-1:0] acc
);
  localparam logic [NUM_POS-1:0] END_MASK =
    {1'b1, {(NUM_POS-2){1'b0}}, 1'b1};

  for (genvar i = 0; i < NUM_POS; i++) begin : g_pos
    if (i == 0 || i == NUM_POS - 1) begin : g_end
      always_ff @(posedge clk) acc[i] <= 1'b1;
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst || clear)  acc[i] <= 1'b0;
        else if (step)     acc[i] <= acc[i] | sample[i];
      end
    end
  end

  assert_ends_set_R3: assert property (@(posedge clk) disable iff (rst)
    acc[0] && acc[NUM_POS-1]);

  assert_monotonic_R2: assert property (@(posedge clk) disable iff (rst)
    !clear |=> ((acc & $past(acc)) == $past(acc)));

  assert_clear_to_mask_R6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc == END_MASK));

  assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!clear && !step) |=> $stable(acc));
endmodule

// File: rtl/pulse_window_monitor.sv
module pulse_window_monitor #(
  parameter int NUM_POS      = 24,
  parameter int EDGES_NEEDED = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic               zoom_in,
  input  logic               pulse_in,
  input  logic [NUM_POS-1:0] marginal_in,
  output logic               zoom_out,
  output logic [NUM_POS-1:0] status_out,
  output logic               valid_out
);
  logic               zoom_q;
  logic               clear;
  logic               rise;
  logic [NUM_POS-1:0] marginal_q;

  always_ff @(posedge clk) begin
    if (rst) zoom_q <= 1'b0;
    else     zoom_q <= zoom_in;
  end

  assign zoom_out = zoom_q;
  assign clear    = restart | (zoom_in ^ zoom_q);

  pwm_edge_detect #(.NUM_POS(NUM_POS)) u_edge (
    .clk(clk), .rst(rst), .pulse_in(pulse_in), .marginal_in(marginal_in),
    .rise(rise), .marginal_q(marginal_q)
  );

  pwm_accum #(.NUM_POS(NUM_POS)) u_acc (
    .clk(clk), .rst(rst), .clear(clear), .step(rise),
    .sample(marginal_q), .acc(status_out)
  );

  pwm_edge_counter #(.EDGES_NEEDED(EDGES_NEEDED)) u_cnt (
    .clk(clk), .rst(rst), .clear(clear), .step(rise), .valid(valid_out)
  );

  assert_zoom_follows_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (zoom_out == $past(zoom_in)));

  assert_zoom_change_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (zoom_in != zoom_out) |=> !valid_out);
endmodule

// File: tb/test_pulse_window_monitor.sv
module test_pulse_window_monitor;
  localparam int N = 24;
  localparam logic [N-1:0] MASK = 24'h800001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0;
  logic zoom_in = 1'b0;
  logic pulse_in = 1'b0;
  logic [N-1:0] marginal_in = '0;
  logic zoom_out;
  logic [N-1:0] status_out;
  logic valid_out;

  int checks = 0;
  int fails = 0;
  logic [N-1:0] lfsr = 24'h5A3C17;

  always #5 clk = ~clk;

  pulse_window_monitor i_pulse_window_monitor (
    .clk(clk), .rst(rst), .restart(restart), .zoom_in(zoom_in),
    .pulse_in(pulse_in), .marginal_in(marginal_in),
    .zoom_out(zoom_out), .status_out(status_out), .valid_out(valid_out)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] next_rand(input logic [N-1:0] s);
    logic [N-1:0] x = s;
    x = x ^ (x << 7);
    x = x ^ (x >> 5);
    x = x ^ (x << 3);
    return (x == 0) ? 24'h1 : x;
  endfunction

  // one pulse edge; leaves the bench at the negedge where the result is visible
  task automatic edge_with(input logic [N-1:0] m);
    pulse_in = 1'b1; marginal_in = m;
    @(negedge clk);
    pulse_in = 1'b0; marginal_in = ~m;
    @(negedge clk);
    marginal_in = '0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] exp_v;
    int edges;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 status in reset", status_out, MASK);
    check("R1 valid in reset", {23'd0, valid_out}, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 status after reset", status_out, MASK);
    check("R1 valid after reset", {23'd0, valid_out}, 24'd0);
    check("R1 zoom after reset", {23'd0, zoom_out}, 24'd0);

    // R2/R3: sweep every position with a one-hot report
    for (int i = 0; i < N; i++) begin
      do_restart();
      edge_with(24'd1 << i);
      check($sformatf("R2 one-hot pos %0d", i), status_out, MASK | (24'd1 << i));
      check("R4 not valid after 1 edge", {23'd0, valid_out}, 24'd0);
    end

    // R3: all-zero reports keep the ends set
    do_restart();
    edge_with('0);
    check("R3 ends forced", status_out, MASK);

    // R2/R4: random multi-edge accumulation
    for (int r = 0; r < 8; r++) begin
      do_restart();
      exp_v = MASK;
      edges = 0;
      for (int e = 0; e < 5; e++) begin
        lfsr = next_rand(lfsr);
        exp_v = exp_v | (lfsr & next_rand(lfsr ^ 24'h0F0F0F));
        edge_with(lfsr & next_rand(lfsr ^ 24'h0F0F0F));
        edges++;
        check("R2 OR accumulation", status_out, exp_v);
        check($sformatf("R4 valid after %0d edges", edges),
              {23'd0, valid_out}, {23'd0, edges >= 3});
      end
    end

    // R5: noise on marginal_in with pulse low is ignored
    do_restart();
    for (int c = 0; c < 10; c++) begin
      lfsr = next_rand(lfsr);
      marginal_in = lfsr;
      @(negedge clk);
    end
    marginal_in = '0;
    @(negedge clk);
    check("R5 no edge no update", status_out, MASK);
    check("R5 no edge no valid", {23'd0, valid_out}, 24'd0);

    // R5: held pulse counts once, only first sample used
    do_restart();
    pulse_in = 1'b1; marginal_in = 24'h000010;
    @(negedge clk);
    for (int c = 0; c < 8; c++) begin
      marginal_in = 24'h0F0F00;
      @(negedge clk);
    end
    pulse_in = 1'b0; marginal_in = '0;
    @(negedge clk);
    check("R5 held pulse single sample", status_out, MASK | 24'h000010);
    edge_with(24'h000100);
    check("R5 held pulse counted once", {23'd0, valid_out}, 24'd0);
    edge_with(24'h000000);
    check("R5 third edge sets valid", {23'd0, valid_out}, 24'd1);

    // R8: latency of two clock edges
    do_restart();
    pulse_in = 1'b1; marginal_in = 24'h002000;
    @(negedge clk);
    pulse_in = 1'b0; marginal_in = '0;
    check("R8 no change after one edge", status_out, MASK);
    @(negedge clk);
    check("R8 change after two edges", status_out, MASK | 24'h002000);

    // R6: restart after valid
    edge_with(24'h000400);
    edge_with(24'h040000);
    check("R4 valid before restart", {23'd0, valid_out}, 24'd1);
    edge_with(24'h000008);
    check("R4 valid saturates", {23'd0, valid_out}, 24'd1);
    do_restart();
    check("R6 restart clears vector", status_out, MASK);
    check("R6 restart clears valid", {23'd0, valid_out}, 24'd0);
    edge_with(24'h0);
    edge_with(24'h0);
    check("R6 count restarted", {23'd0, valid_out}, 24'd0);

    // R7: zoom change clears, steady zoom does not
    edge_with(24'h100000);
    check("R7 valid before zoom change", {23'd0, valid_out}, 24'd1);
    zoom_in = 1'b1;
    @(negedge clk);
    check("R7 zoom_out follows", {23'd0, zoom_out}, 24'd1);
    check("R7 zoom change clears vector", status_out, MASK);
    check("R7 zoom change clears valid", {23'd0, valid_out}, 24'd0);
    edge_with(24'h000200);
    repeat (3) @(negedge clk);
    check("R7 steady zoom keeps vector", status_out, MASK | 24'h000200);
    zoom_in = 1'b0;
    @(negedge clk);
    check("R7 zoom back to coarse", {23'd0, zoom_out}, 24'd0);
    check("R7 second change clears", status_out, MASK);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule